// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port (Master/Slave)

This block is a full-duplex serial peripheral port that a processor drives through two 8-bit registers: a control register and a data register. One byte goes out and one byte comes in at the same time, most significant bit first, with one bit per serial clock period. As master, the port makes the serial clock from the system clock at one of four rates, drives MOSI and samples MISO. As slave, it takes the serial clock, MOSI and an active-low select from outside, and drives MISO back.

The clock idle level and the launch edge can each be set, which gives all four clock modes. When a byte completes, a flag is set and drives the interrupt output. Software clears that flag by writing the bit as zero or by reading the data register. A second flag records any data-register write that arrives while a byte is still shifting. That write is dropped. In slave mode the lowest control bit reads back the live select level.

The master engine uses three states. M_IDLE goes to M_RUN when a start is requested. M_RUN goes to M_DONE after the sixteenth clock edge, or back to M_IDLE if the port is disabled. M_DONE always goes to M_IDLE. The slave engine also uses three states. S_OFF goes to S_DESEL once the port is enabled in slave mode. S_DESEL goes to S_SEL when select falls. S_SEL goes back to S_DESEL when select rises. Every state returns to S_OFF when the port is disabled or switched to master.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the interrupt is low and the output enables for the serial clock, MOSI and MISO are all low.
- R2: In master mode (control bit 5 = 1, bit 4 = 1), a data-register write while idle starts a transfer. The written byte is shifted out MSB first, and the byte sampled from MISO is readable from the data register when the flag is set.
- R3: In master mode the serial clock rests at the level of control bit 3 (1 = high, 0 = low) whenever no byte is shifting.
- R4: Control bit 2 = 0 puts data on the line before the first edge and changes it on each trailing edge, with sampling on leading edges. Control bit 2 = 1 changes data on leading edges and samples on trailing edges. A leading edge is one that leaves the idle level.
- R5: Control bits 1:0 = 00, 01, 10, 11 give a master serial clock half-period of 2, 4, 16 and 32 system clocks.
- R6: Control bit 7 is set at the end of every byte in either mode, and the interrupt output equals it.
- R7: Bit 7 is cleared by writing the control register with bit 7 = 0, or by reading the data register.
- R8: A data-register write during a transfer sets control bit 6 and is otherwise ignored: the byte in flight and the received byte are unaffected. Bit 6 stays set until a control write with bit 6 = 0.
- R9: In slave mode (bit 5 = 1, bit 4 = 0), with select low, the port samples MOSI and shifts out the last written data byte on the external clock. After 8 sample edges it delivers the received byte and sets bit 7.
- R10: In slave mode MISO is driven (enable high) only while select is low and the port is enabled. With bit 2 = 0, the first bit is on MISO as soon as select is low.
- R11: When enabled in slave mode, control bit 0 reads the current select level (after two-stage synchronisation). Otherwise it reads the stored rate bit.
- R12: With bit 5 = 0, a data write starts no transfer: the serial clock stays undriven and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 1 | Register select: 0 = control, 1 = data |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Transfer-complete interrupt |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI in (slave) |
| mosi_o | output | 1 | MOSI out (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO in (master) |
| miso_o | output | 1 | MISO out (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The checks assume the following about the inputs:
- The control register is not rewritten while a byte is shifting.
- As slave, the external serial clock has a half-period of at least four system clocks.
- MOSI changes together with or away from the launch edge, never next to a sample edge, because MOSI and the clock pass through synchronisers of equal depth.
- The select line changes only while the clock is at rest.

The bench keeps to these rules: it plays the far-end master with a half-period of eight system clocks and moves data only on launch edges. As a slave model it reacts to the port's clock one half-period before the next sample edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RUN  = 2'd1,
        M_DONE = 2'd2
    } mst_state_t;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_DESEL = 2'd1,
        S_SEL   = 2'd2
    } slv_state_t;

    typedef struct packed {
        logic       spif;
        logic       wcol;
        logic       en;
        logic       mst;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/spi_port_ratediv.sv
module spi_port_ratediv #(
    parameter int DIV0 = 4,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32,
    parameter int DIV3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] code_i,
    output logic       tick_o
);
    localparam int HC_W = $clog2(DIV3 / 2) + 1;

    logic [HC_W-1:0] cnt_q;
    logic [HC_W-1:0] lim;

    always_comb begin
        unique case (code_i)
            2'd0:    lim = HC_W'(DIV0 / 2 - 1);
            2'd1:    lim = HC_W'(DIV1 / 2 - 1);
            2'd2:    lim = HC_W'(DIV2 / 2 - 1);
            default: lim = HC_W'(DIV3 / 2 - 1);
        endcase
    end

    assign tick_o = run_i && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_port_master.sv
module spi_port_master
    import spi_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIV0 = 4,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32,
    parameter int DIV3 = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic [1:0]    rate_i,
    input  logic          load_i,
    input  logic          start_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int EW = $clog2(2 * DW);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

    mst_state_t    state, nxt;
    logic [EW-1:0] edge_q;
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] rxsh_q;
    logic          sck_q;
    logic          run;
    logic          tick;
    logic          sample_edge;
    logic          launch_edge;

    assign run = (state == M_RUN);

    spi_port_ratediv #(
        .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .code_i (rate_i),
        .tick_o (tick)
    );

    // sample on even edges for phase 0, odd edges for phase 1
    assign sample_edge = (edge_q[0] == cpha_i);
    assign launch_edge = (edge_q[0] != cpha_i) && (edge_q != '0) && (edge_q != LAST_EDGE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE: if (start_i) nxt = M_RUN;
            M_RUN: begin
                if (!en_i)                            nxt = M_IDLE;
                else if (tick && edge_q == LAST_EDGE) nxt = M_DONE;
            end
            M_DONE:  nxt = M_IDLE;
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q  <= '0;
            shreg_q <= '0;
            rxsh_q  <= '0;
            sck_q   <= 1'b0;
        end else begin
            unique case (state)
                M_IDLE: begin
                    sck_q  <= cpol_i;
                    edge_q <= '0;
                    if (load_i) shreg_q <= wdata_i;
                end
                M_RUN: begin
                    if (tick) begin
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + 1'b1;
                        if (sample_edge) rxsh_q  <= {rxsh_q[DW-2:0], miso_i};
                        if (launch_edge) shreg_q <= {shreg_q[DW-2:0], 1'b0};
                    end
                end
                M_DONE: begin
                    sck_q  <= cpol_i;
                    edge_q <= '0;
                end
                default: begin
                    sck_q <= cpol_i;
                end
            endcase
        end
    end

    always_comb begin
        busy_o = (state != M_IDLE);
        done_o = (state == M_DONE);
        rx_o   = rxsh_q;
        mosi_o = shreg_q[DW-1];
        sck_o  = sck_q;
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && sample_edge) |=> $stable(mosi_o));

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_IDLE && $past(state) == M_IDLE && $past(cpol_i) == cpol_i) |-> (sck_o == cpol_i));

endmodule

// File: rtl/spi_port_slave.sv
module spi_port_slave
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          load_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    input  logic          ss_n_i,
    output logic          miso_o,
    output logic          miso_oe_o,
    output logic          ss_lvl_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    slv_state_t    state, nxt;
    logic [2:0]    sck_sr;
    logic [1:0]    mosi_sr;
    logic [1:0]    ss_sr;
    logic          sck_s, sck_d, mosi_s, ss_s;
    logic          sck_edge, leading, trailing;
    logic          sample_ev, launch_ev;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shreg_q;
    logic [DW-1:0] rxsh_q;
    logic [DW-1:0] rx_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sr  <= '0;
            mosi_sr <= '0;
            ss_sr   <= '1;
        end else begin
            sck_sr  <= {sck_sr[1:0], sck_i};
            mosi_sr <= {mosi_sr[0], mosi_i};
            ss_sr   <= {ss_sr[0], ss_n_i};
        end
    end

    assign sck_s  = sck_sr[1];
    assign sck_d  = sck_sr[2];
    assign mosi_s = mosi_sr[1];
    assign ss_s   = ss_sr[1];

    assign sck_edge  = sck_s ^ sck_d;
    assign leading   = sck_edge && (sck_s != cpol_i);
    assign trailing  = sck_edge && (sck_s == cpol_i);
    assign sample_ev = cpha_i ? trailing : leading;
    assign launch_ev = cpha_i ? leading : trailing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (en_i) nxt = S_DESEL;
            S_DESEL: begin
                if (!en_i)      nxt = S_OFF;
                else if (!ss_s) nxt = S_SEL;
            end
            S_SEL: begin
                if (!en_i)     nxt = S_OFF;
                else if (ss_s) nxt = S_DESEL;
            end
            default: nxt = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            rxsh_q  <= '0;
            rx_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load_i && cnt_q == '0) shreg_q <= wdata_i;
            if (state == S_SEL) begin
                if (sample_ev) begin
                    rxsh_q <= {rxsh_q[DW-2:0], mosi_s};
                    if (cnt_q == LAST_BIT) begin
                        cnt_q  <= '0;
                        done_q <= 1'b1;
                        rx_q   <= {rxsh_q[DW-2:0], mosi_s};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else if (launch_ev && cnt_q != '0) begin
                    shreg_q <= {shreg_q[DW-2:0], 1'b0};
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        miso_o    = shreg_q[DW-1];
        miso_oe_o = (state == S_SEL);
        ss_lvl_o  = ss_s;
        busy_o    = (state == S_SEL) && (cnt_q != '0);
        done_o    = done_q;
        rx_o      = rx_q;
    end

    // R10
    ss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !miso_oe_o);

    // R9
    done_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(sample_ev));

endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_data_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [7:0]    wdata_i,
    input  logic          done_i,
    input  logic [DW-1:0] rx_i,
    input  logic          busy_i,
    input  logic          ss_lvl_i,
    output logic [7:0]    rdata_o,
    output logic          irq_o,
    output logic          en_o,
    output logic          mst_o,
    output logic          cpol_o,
    output logic          cpha_o,
    output logic [1:0]    rate_o
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] rxbuf_q;
    logic          wr_ctrl, wr_data, rd_data, coll;

    assign wr_ctrl = wr_i && !sel_data_i;
    assign wr_data = wr_i && sel_data_i;
    assign rd_data = rd_i && sel_data_i;
    assign coll    = wr_data && busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            rxbuf_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en   <= wdata_i[5];
                ctrl_q.mst  <= wdata_i[4];
                ctrl_q.cpol <= wdata_i[3];
                ctrl_q.cpha <= wdata_i[2];
                ctrl_q.rate <= wdata_i[1:0];
            end
            if (done_i)                       ctrl_q.spif <= 1'b1;
            else if (wr_ctrl && !wdata_i[7])  ctrl_q.spif <= 1'b0;
            else if (rd_data)                 ctrl_q.spif <= 1'b0;
            if (coll)                         ctrl_q.wcol <= 1'b1;
            else if (wr_ctrl && !wdata_i[6])  ctrl_q.wcol <= 1'b0;
            if (done_i) rxbuf_q <= rx_i;
        end
    end

    always_comb begin
        if (sel_data_i) begin
            rdata_o = 8'(rxbuf_q);
        end else begin
            rdata_o = {ctrl_q.spif, ctrl_q.wcol, ctrl_q.en, ctrl_q.mst,
                       ctrl_q.cpol, ctrl_q.cpha, ctrl_q.rate[1],
                       (ctrl_q.en && !ctrl_q.mst) ? ss_lvl_i : ctrl_q.rate[0]};
        end
        irq_o  = ctrl_q.spif;
        en_o   = ctrl_q.en;
        mst_o  = ctrl_q.mst;
        cpol_o = ctrl_q.cpol;
        cpha_o = ctrl_q.cpha;
        rate_o = ctrl_q.rate;
    end

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.spif) |-> $past(done_i));

    // R8
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.wcol) |-> $past(wr_i && sel_data_i && busy_i));

    // R7
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && sel_data_i && !done_i) |=> !irq_o);

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DIV0 = 4,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32,
    parameter int DIV3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe_o,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe_o,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe_o,
    input  logic       ss_n_i
);
    logic          en, mst, cpol, cpha;
    logic [1:0]    rate;
    logic          wr_data;
    logic          m_busy, m_done, s_busy, s_done, ss_lvl;
    logic [DW-1:0] m_rx, s_rx, rx_sel;
    logic          m_en, s_en, m_start, m_load, s_load;

    assign wr_data = wr_en_i && reg_sel_i;
    assign m_en    = en && mst;
    assign s_en    = en && !mst;
    assign m_load  = wr_data && !m_busy;
    assign m_start = m_load && m_en;
    assign s_load  = wr_data && !s_busy;
    assign rx_sel  = m_done ? m_rx : s_rx;

    spi_port_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_data_i (reg_sel_i),
        .wr_i       (wr_en_i),
        .rd_i       (rd_en_i),
        .wdata_i    (wdata_i),
        .done_i     (m_done || s_done),
        .rx_i       (rx_sel),
        .busy_i     (m_busy || s_busy),
        .ss_lvl_i   (ss_lvl),
        .rdata_o    (rdata_o),
        .irq_o      (irq_o),
        .en_o       (en),
        .mst_o      (mst),
        .cpol_o     (cpol),
        .cpha_o     (cpha),
        .rate_o     (rate)
    );

    spi_port_master #(
        .DW(DW), .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
    ) u_mst (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (m_en),
        .cpol_i  (cpol),
        .cpha_i  (cpha),
        .rate_i  (rate),
        .load_i  (m_load),
        .start_i (m_start),
        .wdata_i (wdata_i[DW-1:0]),
        .miso_i  (miso_i),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .busy_o  (m_busy),
        .done_o  (m_done),
        .rx_o    (m_rx)
    );

    spi_port_slave #(.DW(DW)) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (s_en),
        .cpol_i    (cpol),
        .cpha_i    (cpha),
        .load_i    (s_load),
        .wdata_i   (wdata_i[DW-1:0]),
        .sck_i     (sck_i),
        .mosi_i    (mosi_i),
        .ss_n_i    (ss_n_i),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe_o),
        .ss_lvl_o  (ss_lvl),
        .busy_o    (s_busy),
        .done_o    (s_done),
        .rx_o      (s_rx)
    );

    assign sck_oe_o  = m_en;
    assign mosi_oe_o = m_en;

    // R12
    no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !m_busy) |=> !m_busy);

endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       sck_i = 1'b0;
    logic       sck_o, sck_oe;
    logic       mosi_i = 1'b0;
    logic       mosi_o, mosi_oe;
    logic       miso_i = 1'b0;
    logic       miso_o, miso_oe;
    logic       ss_n = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel_i (reg_sel),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq),
        .sck_i     (sck_i),
        .sck_o     (sck_o),
        .sck_oe_o  (sck_oe),
        .mosi_i    (mosi_i),
        .mosi_o    (mosi_o),
        .mosi_oe_o (mosi_oe),
        .miso_i    (miso_i),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe),
        .ss_n_i    (ss_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic bus_rd_clear();
        @(negedge clk);
        reg_sel = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek_ctrl(output logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b0;
        #1 v = rdata;
        reg_sel = 1'b1;
    endtask

    task automatic wait_irq();
        for (int g = 0; g < 5000 && !irq; g++) @(negedge clk);
    endtask

    // scoreboard monitor: each completion must deliver the next expected byte
    initial begin
        logic prev = 1'b0;
        forever begin
            @(posedge clk);
            #3;
            if (irq && !prev) begin
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected completion", 32'(irq), 32'h0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk("R2/R9 received byte", 32'(rdata), 32'(e));
                end
            end
            prev = irq;
        end
    end

    task automatic master_xfer(input logic pol, input logic pha, input logic [1:0] rc,
                               input logic [7:0] tx, input logic [7:0] pat,
                               input bit coll, input bit wclr);
        int half;
        int idx = 0;
        int b = 0;
        int last = 0;
        bit rate_ok = 1;
        bit did = 0;
        logic prev;
        logic [7:0] cap = '0;
        logic [7:0] v;
        half = (rc == 2'd0) ? 2 : (rc == 2'd1) ? 4 : (rc == 2'd2) ? 16 : 32;
        bus_wr(1'b0, {2'b00, 1'b1, 1'b1, pol, pha, rc});
        repeat (2) @(negedge clk);
        chk("R3 idle clock level", 32'(sck_o), 32'(pol));
        chk("R2 clock driven in master", 32'(sck_oe & mosi_oe), 32'h1);
        miso_i = pat[7];
        prev = sck_o;
        exp_q.push_back(pat);
        bus_wr(1'b1, tx);
        for (int g = 0; g < 20000 && idx < 16; g++) begin
            @(negedge clk);
            if (coll && idx == 6 && !did) begin
                did = 1;
                bus_wr(1'b1, 8'h00);
            end
            if (sck_o !== prev) begin
                logic lead;
                logic samp;
                prev = sck_o;
                if (idx > 0 && (cyc - last) != half) rate_ok = 0;
                last = cyc;
                lead = (sck_o != pol);
                samp = pha ? !lead : lead;
                if (samp) begin
                    cap = {cap[6:0], mosi_o};
                end else if (idx != 0 && idx != 15) begin
                    b++;
                    miso_i = pat[7-b];
                end
                idx++;
            end
        end
        wait_irq();
        chk("R2/R4 MOSI byte", 32'(cap), 32'(tx));
        if (!coll) chk("R5 clock half period", 32'(rate_ok), 32'h1);
        chk("R6 irq after byte", 32'(irq), 32'h1);
        repeat (2) @(negedge clk);
        chk("R3 clock back at idle", 32'(sck_o), 32'(pol));
        if (coll) begin
            peek_ctrl(v);
            chk("R8 collision flag set", 32'(v[6]), 32'h1);
        end
        if (wclr) begin
            bus_wr(1'b0, {1'b0, coll ? 1'b1 : 1'b0, 1'b1, 1'b1, pol, pha, rc});
            peek_ctrl(v);
            chk("R7 flag cleared by control write", 32'(v[7]), 32'h0);
        end else begin
            bus_rd_clear();
            chk("R7 flag cleared by data read", 32'(irq), 32'h0);
        end
        if (coll) begin
            peek_ctrl(v);
            chk("R8 collision flag held", 32'(v[6]), 32'h1);
            bus_wr(1'b0, {2'b00, 1'b1, 1'b1, pol, pha, rc});
            peek_ctrl(v);
            chk("R8 collision flag cleared by write", 32'(v[6]), 32'h0);
        end
    endtask

    task automatic slave_xfer(input logic pol, input logic pha,
                              input logic [7:0] tx, input logic [7:0] pat);
        int kb = 0;
        logic [7:0] cap = '0;
        logic [7:0] v;
        sck_i = pol;
        ss_n = 1'b1;
        bus_wr(1'b0, {2'b00, 1'b1, 1'b0, pol, pha, 2'b00});
        repeat (6) @(negedge clk);
        peek_ctrl(v);
        chk("R11 select level high", 32'(v[0]), 32'h1);
        chk("R10 MISO released when deselected", 32'(miso_oe), 32'h0);
        bus_wr(1'b1, tx);
        exp_q.push_back(pat);
        mosi_i = pat[7];
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        peek_ctrl(v);
        chk("R11 select level low", 32'(v[0]), 32'h0);
        chk("R10 MISO driven when selected", 32'(miso_oe), 32'h1);
        if (!pha) chk("R10 first bit ready at select", 32'(miso_o), 32'(tx[7]));
        for (int idx = 0; idx < 16; idx++) begin
            logic lead;
            logic launch;
            lead = (idx % 2 == 0);
            launch = pha ? lead : !lead;
            if (launch) begin
                if (idx != 0 && idx != 15) begin
                    kb++;
                    mosi_i = pat[7-kb];
                end
            end else begin
                cap = {cap[6:0], miso_o};
            end
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
        end
        wait_irq();
        chk("R9 MISO byte", 32'(cap), 32'(tx));
        chk("R9 completion flag", 32'(irq), 32'h1);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 MISO released after select", 32'(miso_oe), 32'h0);
        bus_rd_clear();
        chk("R7 slave flag cleared by read", 32'(irq), 32'h0);
    endtask

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        peek_ctrl(v);
        chk("R1 control reset value", 32'(v), 32'h0);
        chk("R1 irq low", 32'(irq), 32'h0);
        chk("R1 enables low", 32'({sck_oe, mosi_oe, miso_oe}), 32'h0);

        // R12 disabled master: write does nothing
        bus_wr(1'b0, 8'h10);
        bus_wr(1'b1, 8'hA5);
        repeat (100) @(negedge clk);
        chk("R12 clock undriven", 32'(sck_oe), 32'h0);
        chk("R12 no flag", 32'(irq), 32'h0);
        peek_ctrl(v);
        chk("R12 control unchanged", 32'(v), 32'h10);

        // master: all modes and rates
        master_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 0, 0);
        master_xfer(1'b1, 1'b0, 2'd1, 8'h96, 8'hC3, 0, 1);
        master_xfer(1'b0, 1'b1, 2'd2, 8'h01, 8'h80, 0, 0);
        master_xfer(1'b1, 1'b1, 2'd3, 8'hF0, 8'h0F, 0, 1);
        // R8 collision mid-transfer
        master_xfer(1'b0, 1'b1, 2'd3, 8'h5A, 8'hE7, 1, 0);

        // slave: all four modes
        slave_xfer(1'b0, 1'b0, 8'hC6, 8'h35);
        slave_xfer(1'b1, 1'b0, 8'h81, 8'h7E);
        slave_xfer(1'b0, 1'b1, 8'h2B, 8'hD4);
        slave_xfer(1'b1, 1'b1, 8'hE1, 8'h19);

        // R10 disabled slave releases MISO even when selected
        ss_n = 1'b0;
        bus_wr(1'b0, 8'h00);
        repeat (4) @(negedge clk);
        chk("R10 MISO released when disabled", 32'(miso_oe), 32'h0);
        ss_n = 1'b1;

        repeat (10) @(negedge clk);
        chk("R2/R9 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule